// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge and Level Interrupt

This block is one parameterizable port of general-purpose pins. A small register set sits behind a simple synchronous bus. For each pin it holds an output value latch, a direction bit and an option bit. The meaning of the option bit depends on the direction. On an output pin it picks between push-pull and open-drain drive. On an input pin it arms the external interrupt. The pad is driven through separate value and enable signals.

Every input pin passes through a two-stage synchronizer. An edge detector follows the synchronizer, and its sensitivity is set once for the whole port. While a pin's interrupt is not armed, the detector sees a constant high. Arming or disarming a pin that sits low is therefore a genuine edge, and it is counted under the sensitivity in force at that moment. Edge events set sticky pending bits, which software clears by writing ones. A level mode raises the request for as long as an armed pin is low. A global mask input gates the request line.

Top module: `gpio_irq_port`

## Requirements
- R1: Writing address 0 stores the output value latch. Reading address 0 returns the stored latch and not the pin level.
- R2: A pin whose direction bit (address 1) is 1 is an output. With its option bit (address 2) at 1 it is push-pull: `pin_oe`=1 and `pin_out` equals the latch. With the option bit at 0 it is open-drain: `pin_oe` is 1 only while the latch bit is 0.
- R3: A latch value written while the pin is an input is kept. In the first cycle after the direction write takes effect, the pin drives that value.
- R4: A pin change reaches the detector after two clock edges. An edge event shows in the pending bits on the third edge. Address 5 reads the synchronized pin levels.
- R5: An input pin whose option bit is 0, and any output pin, presents a constant 1 to the detector. Activity on such a pin raises no event.
- R6: Setting the option bit of an input pin that is low makes a falling edge. Clearing it makes a rising edge. Each is counted only if the current sensitivity includes that direction.
- R7: The sensitivity sits at address 3, bits [1:0]: 00 = level low, 01 = rising only, 10 = falling only, 11 = both edges. An edge is judged by the setting in force when it reaches the detector.
- R8: In level mode 00, `irq` is high while any armed input is low, and no pending bit is set.
- R9: Pending bits (address 4) are sticky and cleared by writing 1. Writing 0 leaves them unchanged. `irq` is the OR of all pending bits and the level request, forced low while `irq_mask`=1.
- R10: Reset clears the latch, direction, option, sensitivity and pending registers. Every pin starts as an input with its interrupt disarmed, `pin_oe`=0 and `irq`=0.
- R11: `bus_rdata` returns the register at `bus_addr` one cycle after the address is presented. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, one cycle after the address |
| pin_in | input | NPIN | Asynchronous pad levels |
| pin_out | output | NPIN | Pad drive value |
| pin_oe | output | NPIN | Pad drive enable |
| irq_mask | input | 1 | Global mask; 1 blocks the request |
| irq | output | 1 | Interrupt request |

## Verification
The detector is tried with a falling transition, then a rising transition under the falling-only setting, and then both under the both-edges setting. These runs tell a correct sensitivity decode apart from one that inverts or ignores the direction. Arming and disarming a pin held low shows that the forced-high detector input creates real edges. Disarming under falling-only shows the sensitivity filter still applies to those edges. Toggling a disarmed input and an output pin shows that the detector is not fed through those paths. A low input in level mode separates the continuous request from the sticky pending path.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic            irq_mask,
  output logic            irq
);
  localparam logic [AW-1:0] A_LAT  = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_OPT  = AW'(2);
  localparam logic [AW-1:0] A_SENS = AW'(3);
  localparam logic [AW-1:0] A_PEND = AW'(4);
  localparam logic [AW-1:0] A_LVL  = AW'(5);

  logic [NPIN-1:0] lat_q, dir_q, opt_q, pend_q, sy1_q, sy2_q, det_prev_q;
  logic [1:0]      sens_q;
  logic [NPIN-1:0] armed, det_in, fall, rise, evt, rd_mux;
  logic            level_req;

  assign armed  = ~dir_q & opt_q;
  assign det_in = ~armed | sy2_q;
  assign fall   = det_prev_q & ~det_in;
  assign rise   = ~det_prev_q & det_in;

  always_comb begin
    case (sens_q)
      2'b01:   evt = rise;
      2'b10:   evt = fall;
      2'b11:   evt = rise | fall;
      default: evt = '0;
    endcase
  end

  assign level_req = (sens_q == 2'b00) && |(armed & ~sy2_q);
  assign irq       = ~irq_mask & ((|pend_q) | level_req);
  assign pin_out   = lat_q;
  assign pin_oe    = dir_q & (opt_q | ~lat_q);

  always_comb begin
    case (bus_addr)
      A_LAT:   rd_mux = lat_q;
      A_DIR:   rd_mux = dir_q;
      A_OPT:   rd_mux = opt_q;
      A_SENS:  rd_mux = NPIN'(sens_q);
      A_PEND:  rd_mux = pend_q;
      A_LVL:   rd_mux = sy2_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q      <= '0;
      dir_q      <= '0;
      opt_q      <= '0;
      sens_q     <= 2'b00;
      pend_q     <= '0;
      sy1_q      <= '1;
      sy2_q      <= '1;
      det_prev_q <= '1;
      bus_rdata  <= '0;
    end else begin
      sy1_q      <= pin_in;
      sy2_q      <= sy1_q;
      det_prev_q <= det_in;
      bus_rdata  <= rd_mux;
      if (bus_we && bus_addr == A_LAT)  lat_q  <= bus_wdata;
      if (bus_we && bus_addr == A_DIR)  dir_q  <= bus_wdata;
      if (bus_we && bus_addr == A_OPT)  opt_q  <= bus_wdata;
      if (bus_we && bus_addr == A_SENS) sens_q <= bus_wdata[1:0];
      pend_q <= (pend_q & ~((bus_we && bus_addr == A_PEND) ? bus_wdata : '0)) | evt;
    end
  end
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 8,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq_mask,
  input logic            irq,
  input logic [NPIN-1:0] pend_q,
  input logic [1:0]      sens_q
);
  // R10: first cycle out of reset
  a_r10_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pin_oe == '0 && pend_q == '0));

  // R9: a pending bit only drops after a write to the pending address
  a_r9_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_q) & ~pend_q)) |-> ($past(bus_we) && $past(bus_addr) == AW'(4)));

  // R9: the mask blocks the request
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  // R1: the output latch changes only through a write to address 0
  a_r1_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(bus_we) && $past(bus_addr) == AW'(0)) |-> $stable(pin_out));

  // R8: level mode never sets a pending bit
  a_r8_level_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~$past(pend_q))) |-> ($past(sens_q) != 2'b00));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq_mask(irq_mask), .irq(irq),
  .pend_q(pend_q), .sens_q(sens_q)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic       clk = 0, rst_n = 0;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = '0, bus_rdata, pin_in = 8'hFF, pin_out, pin_oe;
  logic       irq_mask = 0, irq;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  gpio_irq_port #(.NPIN(8), .AW(3)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_we = 0;
    @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check(pin_oe == 0, "R10 oe", pin_oe, 0);
    check(irq == 0, "R10 irq", irq, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      check(rv == 0, "R10 reg", rv, 0);
    end
    rd(3'd7, rv);
    check(rv == 0, "R11 unused addr", rv, 0);
  endtask

  task automatic t_output;
    wr(0, 8'hA5);
    check(pin_oe == 0, "R3 input not driven", pin_oe, 0);
    rd(0, rv);
    check(rv == 8'hA5, "R1 latch readback", rv, 8'hA5);
    wr(2, 8'hFF);
    wr(1, 8'hFF);
    check(pin_oe == 8'hFF, "R3 first output cycle oe", pin_oe, 8'hFF);
    check(pin_out == 8'hA5, "R3 first output cycle value", pin_out, 8'hA5);
    pin_in = 8'h00;
    idle(3);
    rd(0, rv);
    check(rv == 8'hA5, "R1 latch not pin", rv, 8'hA5);
    pin_in = 8'hFF;
    wr(2, 8'h00);
    check(pin_oe == 8'h5A, "R2 open-drain", pin_oe, 8'h5A);
    wr(2, 8'hF0);
    check(pin_oe == 8'hFA, "R2 mixed drive", pin_oe, 8'hFA);
    wr(2, 8'h00);
    wr(1, 8'h00);
    wr(0, 8'h00);
    idle(3);
    rd(4, rv);
    check(rv == 0, "R5 no pending from output phase", rv, 0);
  endtask

  task automatic t_falling;
    wr(3, 8'h02);
    wr(2, 8'h01);
    @(negedge clk); pin_in[0] = 0;
    idle(2);
    check(irq == 0, "R4 not yet", irq, 0);
    idle(1);
    check(irq == 1, "R4 third edge", irq, 1);
    irq_mask = 1; #1;
    check(irq == 0, "R9 mask", irq, 0);
    irq_mask = 0;
    wr(4, 8'h00); idle(1);
    rd(4, rv);
    check(rv == 8'h01, "R9 write 0 keeps", rv, 8'h01);
    wr(4, 8'h01); idle(1);
    rd(4, rv);
    check(rv == 8'h00, "R9 write 1 clears", rv, 0);
    pin_in[0] = 1;
    idle(4);
    rd(4, rv);
    check(rv == 0 && irq == 0, "R7 rising ignored under falling", rv, 0);
  endtask

  task automatic t_arm_low;
    pin_in[1] = 0;
    idle(4);
    rd(4, rv);
    check(rv == 0, "R5 disarmed pin quiet", rv, 0);
    wr(2, 8'h03); idle(1);
    rd(4, rv);
    check(rv == 8'h02, "R6 arm while low", rv, 8'h02);
    wr(4, 8'hFF);
    wr(3, 8'h01);
    wr(2, 8'h01); idle(1);
    rd(4, rv);
    check(rv == 8'h02, "R6 disarm while low rising", rv, 8'h02);
    wr(4, 8'hFF);
    wr(3, 8'h02);
    wr(2, 8'h03); idle(1);
    wr(4, 8'hFF);
    wr(2, 8'h01); idle(1);
    rd(4, rv);
    check(rv == 0, "R6 disarm under falling ignored", rv, 0);
  endtask

  task automatic t_both;
    wr(3, 8'h03);
    wr(2, 8'h05);
    pin_in[2] = 0;
    idle(4);
    rd(4, rv);
    check(rv == 8'h04, "R7 both falling", rv, 8'h04);
    wr(4, 8'h04);
    pin_in[2] = 1;
    idle(4);
    rd(4, rv);
    check(rv == 8'h04, "R7 both rising", rv, 8'h04);
    wr(4, 8'hFF);
  endtask

  task automatic t_level;
    wr(3, 8'h00);
    wr(2, 8'h08);
    @(negedge clk); pin_in[3] = 0;
    idle(1);
    check(irq == 0, "R8 level sync delay", irq, 0);
    idle(1);
    check(irq == 1, "R8 level asserted", irq, 1);
    idle(3);
    check(irq == 1, "R8 level held", irq, 1);
    rd(4, rv);
    check(rv == 0, "R8 no pending", rv, 0);
    pin_in[3] = 1;
    idle(2);
    check(irq == 0, "R8 level released", irq, 0);
  endtask

  task automatic t_out_quiet;
    wr(3, 8'h03);
    wr(2, 8'h10);
    wr(1, 8'h10);
    pin_in[4] = 0; idle(4);
    pin_in[4] = 1; idle(4);
    rd(4, rv);
    check(rv == 0 && irq == 0, "R5 output pin quiet", rv, 0);
    wr(1, 8'h00);
    wr(2, 8'h00);
  endtask

  task automatic t_level_read;
    pin_in = 8'h3C;
    idle(2);
    rd(5, rv);
    check(rv == 8'h3C, "R4 pin level read", rv, 8'h3C);
    rd(3, rv);
    check(rv == 8'h03, "R11 sensitivity read", rv, 8'h03);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    t_output();
    t_falling();
    t_arm_low();
    t_both();
    t_level();
    t_out_quiet();
    t_level_read();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200us;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule